// File: doc/BRIEF.md
# Ethernet PHY Status Indicator Controller

This block drives the three status LEDs and the cable-or-link status pin of a 10/100 Ethernet PHY. It takes link, speed, duplex, cable-present, activity and collision indications, together with a map-select pin and the level that each output pin sees on its board strap while reset is held. From these it produces registered pin levels. The polarity of each pin and the meaning of the status pin follow from the sampled straps.

After a hardware reset or a soft-reset pulse, all three LEDs light together for one boot window, and after that they show status. With the map select high, each LED carries one indication. With it low, two LEDs share a combined link and speed code and the third LED shows duplex. Activity and collision events are one-cycle pulses. Each one blanks the LED it affects for a stretch window, so that a short burst stays visible. A free-running prescaler sets the timebase: one tick every `TICK_DIV` clocks. The boot window lasts `BOOT_TICKS` ticks and the stretch window lasts `HOLD_TICKS` ticks.

Top module: `phy_led_ctrl`

## Requirements
- R1: The strap inputs are sampled while `rst` is high, and the value held at the last reset cycle is kept until the next hardware reset. Changing `led_strap` or `sts_strap` after reset changes no output.
- R2: After `rst` is released, all three LEDs are lit for `BOOT_TICKS*TICK_DIV` clock cycles (plus one cycle of output register). After that they show status.
- R3: A one-cycle `soft_rst` pulse restarts the full boot window: all LEDs are lit again and then return to status. The straps are not re-sampled.
- R4: Each LED pin level is its lit state XOR its captured strap. A pin strapped 1 is driven 0 when lit, and a pin strapped 0 is driven 1 when lit.
- R5: When `led_mode`=1 (single map), LED0 is lit for full duplex, LED1 is lit for 100 Mb/s, and LED2 is lit while the link is up.
- R6: In the single map, a one-cycle `activity` pulse blanks LED2 within two cycles. LED2 stays dark for at least `(HOLD_TICKS-1)*TICK_DIV` cycles and comes back after at most `(HOLD_TICKS+1)*TICK_DIV` cycles.
- R7: When `led_mode`=0 (dual map), both LED0 and LED1 are dark with no link. With link up at 100 Mb/s, LED0 is lit and LED1 is dark. With link up at 10 Mb/s, LED1 is lit and LED0 is dark.
- R8: In the dual map, an `activity` pulse blanks whichever of LED0 and LED1 is lit, for the stretch window.
- R9: In the dual map, LED2 is lit for full duplex and dark for half duplex. A `collision` pulse inverts LED2 for the stretch window.
- R10: In the single map, `collision` has no effect on any pin.
- R11: With `sts_strap` captured as 0, `sts_pin` equals `cable_present` (1 means a cable is connected).
- R12: With `sts_strap` captured as 1, `sts_pin` is 0 while the link is up and 1 while it is down.
- R13: While `rst` is high, each LED pin is driven to its unlit level (equal to its strap input), and `sts_pin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| soft_rst | input | 1 | One-cycle pulse that restarts the boot indication |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex |
| activity | input | 1 | Traffic event pulse |
| collision | input | 1 | Collision event pulse |
| cable_present | input | 1 | Cable detected |
| led_mode | input | 1 | 1 = single map, 0 = dual map |
| led_strap | input | 3 | Strap level seen on each LED pin during reset |
| sts_strap | input | 1 | Strap level seen on the status pin during reset |
| led_pin | output | 3 | LED pin levels, bit i drives LED i |
| sts_pin | output | 1 | Cable or link status pin level |

## Verification
The properties take `rst` to be synchronous to `clk`. They also take the status inputs to be quasi-static levels, and `activity`, `collision` and `soft_rst` to be pulses sampled on clock edges. Under those conditions, each registered pin reflects the inputs of the previous cycle. The bench changes every input only on the falling edge. It holds each level for several cycles before sampling, and it issues soft-reset pulses only outside hardware reset. As a result, each output check falls after the single register stage and, for the timed windows, well inside or well past the prescaler tick bounds.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
  localparam int NUM_LED = 3;

  typedef enum logic {
    MAP_DUAL   = 1'b0,
    MAP_SINGLE = 1'b1
  } led_map_e;

  typedef struct packed {
    logic link;
    logic fast;
    logic fdx;
  } phy_stat_t;
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] div_cnt;

  assign tick = (div_cnt == CW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  div_cnt <= '0;
    else if (tick)   div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/led_boot_timer.sv
module led_boot_timer #(
  parameter int BOOT_TICKS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic active
);
  localparam int BW = $clog2(BOOT_TICKS + 1);

  logic [BW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst || restart)      left_q <= BW'(BOOT_TICKS);
    else if (tick && active) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
  parameter int HOLD_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic evt,
  output logic hold
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] hold_q;

  assign hold = (hold_q != '0);

  always_ff @(posedge clk) begin
    if (rst || clr)        hold_q <= '0;
    else if (evt)          hold_q <= HW'(HOLD_TICKS);
    else if (tick && hold) hold_q <= hold_q - 1'b1;
  end
endmodule

// File: rtl/led_map.sv
module led_map
  import phy_led_pkg::*;
(
  input  led_map_e             mode,
  input  phy_stat_t            st,
  input  logic                 boot,
  input  logic                 act_hold,
  input  logic                 col_hold,
  input  logic [NUM_LED-1:0]   strap,
  output logic [NUM_LED-1:0]   pin_d
);
  logic [NUM_LED-1:0] lit;

  always_comb begin
    lit = '0;
    if (boot) begin
      lit = '1;
    end else if (mode == MAP_SINGLE) begin
      lit[0] = st.fdx;
      lit[1] = st.fast;
      lit[2] = st.link && !act_hold;
    end else begin
      lit[0] = st.link && st.fast && !act_hold;
      lit[1] = st.link && !st.fast && !act_hold;
      lit[2] = st.fdx ^ col_hold;
    end
  end

  for (genvar gi = 0; gi < NUM_LED; gi++) begin : g_pol
    assign pin_d[gi] = lit[gi] ^ strap[gi];
  end
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int TICK_DIV   = 125000,
  parameter int BOOT_TICKS = 500,
  parameter int HOLD_TICKS = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic               link_up,
  input  logic               speed_100,
  input  logic               full_duplex,
  input  logic               activity,
  input  logic               collision,
  input  logic               cable_present,
  input  logic               led_mode,
  input  logic [NUM_LED-1:0] led_strap,
  input  logic               sts_strap,
  output logic [NUM_LED-1:0] led_pin,
  output logic               sts_pin
);
  logic [NUM_LED-1:0] strap_q;
  logic               sts_strap_q;
  logic               tick;
  logic               boot_act;
  logic               act_hold;
  logic               col_hold;
  logic [NUM_LED-1:0] pin_d;
  phy_stat_t          st;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q     <= led_strap;
      sts_strap_q <= sts_strap;
    end
  end

  led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(soft_rst), .tick(tick)
  );

  led_boot_timer #(.BOOT_TICKS(BOOT_TICKS)) u_boot (
    .clk(clk), .rst(rst), .restart(soft_rst), .tick(tick), .active(boot_act)
  );

  led_pulse_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_act (
    .clk(clk), .rst(rst), .clr(soft_rst), .tick(tick), .evt(activity),
    .hold(act_hold)
  );

  led_pulse_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_col (
    .clk(clk), .rst(rst), .clr(soft_rst), .tick(tick), .evt(collision),
    .hold(col_hold)
  );

  assign st = '{link: link_up, fast: speed_100, fdx: full_duplex};

  led_map u_map (
    .mode(led_map_e'(led_mode)), .st(st), .boot(boot_act),
    .act_hold(act_hold), .col_hold(col_hold), .strap(strap_q), .pin_d(pin_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_pin <= led_strap;
      sts_pin <= 1'b0;
    end else begin
      led_pin <= pin_d;
      sts_pin <= sts_strap_q ? !link_up : cable_present;
    end
  end
endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk (
  input logic       clk,
  input logic       rst,
  input logic       soft_rst,
  input logic       link_up,
  input logic       full_duplex,
  input logic       activity,
  input logic       collision,
  input logic       cable_present,
  input logic       led_mode,
  input logic [2:0] led_pin,
  input logic       sts_pin,
  input logic [2:0] strap_q,
  input logic       sts_strap_q,
  input logic       boot_act,
  input logic       act_hold,
  input logic       col_hold
);
  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(strap_q));

  // R2
  boot_lit_chk: assert property (@(posedge clk) disable iff (rst)
    boot_act |=> (led_pin == ~strap_q));

  // R3
  soft_boot_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> boot_act);

  // R5
  single_dup_chk: assert property (@(posedge clk) disable iff (rst)
    (!boot_act && led_mode) |=> (led_pin[0] == ($past(full_duplex) ^ strap_q[0])));

  // R6
  act_seen_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    activity |=> act_hold);

  // R9
  col_seen_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    collision |=> col_hold);

  // R11
  sts_cable_chk: assert property (@(posedge clk) disable iff (rst)
    !sts_strap_q |=> (sts_pin == $past(cable_present)));

  // R12
  sts_link_chk: assert property (@(posedge clk) disable iff (rst)
    sts_strap_q |=> (sts_pin == !$past(link_up)));
endmodule

bind phy_led_ctrl phy_led_chk chk_i (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .link_up(link_up),
  .full_duplex(full_duplex), .activity(activity), .collision(collision),
  .cable_present(cable_present), .led_mode(led_mode), .led_pin(led_pin),
  .sts_pin(sts_pin), .strap_q(strap_q), .sts_strap_q(sts_strap_q),
  .boot_act(boot_act), .act_hold(act_hold), .col_hold(col_hold)
);

// File: tb/phy_led_ctrl_tb_top.sv
module phy_led_ctrl_tb_top;
  localparam int DIV  = 4;
  localparam int BOOT = 5;
  localparam int HOLD = 3;
  localparam int BOOTC = DIV * BOOT;

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0;
  logic link_up = 1'b0, speed_100 = 1'b0, full_duplex = 1'b0;
  logic activity = 1'b0, collision = 1'b0, cable_present = 1'b0;
  logic led_mode = 1'b1;
  logic [2:0] led_strap = 3'b101;
  logic sts_strap = 1'b0;
  logic [2:0] led_pin;
  logic sts_pin;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phy_led_ctrl #(.TICK_DIV(DIV), .BOOT_TICKS(BOOT), .HOLD_TICKS(HOLD)) dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .link_up(link_up),
    .speed_100(speed_100), .full_duplex(full_duplex), .activity(activity),
    .collision(collision), .cable_present(cable_present), .led_mode(led_mode),
    .led_strap(led_strap), .sts_strap(sts_strap), .led_pin(led_pin),
    .sts_pin(sts_pin)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // R13, R2, R4, R5, R1
  task automatic t_reset_boot(input logic [2:0] ls, input logic ss);
    rst = 1'b1; led_strap = ls; sts_strap = ss;
    cyc(3);
    chk("R13 pins in reset", {1'b0, led_pin}, {1'b0, ls});
    chk("R13 sts in reset", {3'b0, sts_pin}, 4'h0);
    rst = 1'b0;
    cyc(2);
    chk("R2 boot lit early", {1'b0, led_pin}, {1'b0, ~ls});
    led_strap = ~ls; sts_strap = ~ss;
    cyc(15);
    chk("R2 boot lit late", {1'b0, led_pin}, {1'b0, ~ls});
    cyc(7);
  endtask

  // R5, R4, R1
  task automatic t_single_map();
    led_mode = 1'b1; link_up = 1'b1; speed_100 = 1'b1; full_duplex = 1'b0;
    cyc(4);
    chk("R5 link 100 half", {1'b0, led_pin}, {1'b0, 3'b110 ^ 3'b101});
    chk("R1 strap change ignored", {1'b0, led_pin}, 4'h3);
    link_up = 1'b0; speed_100 = 1'b0; full_duplex = 1'b1;
    cyc(4);
    chk("R5 nolink 10 full", {1'b0, led_pin}, {1'b0, 3'b001 ^ 3'b101});
  endtask

  // R6, R10
  task automatic t_single_events();
    led_mode = 1'b1; link_up = 1'b1; speed_100 = 1'b1; full_duplex = 1'b1;
    cyc(4);
    chk("R5 all lit", {1'b0, led_pin}, {1'b0, 3'b111 ^ 3'b101});
    activity = 1'b1; cyc(1); activity = 1'b0;
    cyc(2);
    chk("R6 led2 blanked", {1'b0, led_pin}, {1'b0, 3'b011 ^ 3'b101});
    cyc(5);
    chk("R6 still blanked", {1'b0, led_pin}, {1'b0, 3'b011 ^ 3'b101});
    cyc(13);
    chk("R6 led2 back", {1'b0, led_pin}, {1'b0, 3'b111 ^ 3'b101});
    collision = 1'b1; cyc(1); collision = 1'b0;
    cyc(2);
    chk("R10 collision ignored early", {1'b0, led_pin}, {1'b0, 3'b111 ^ 3'b101});
    cyc(5);
    chk("R10 collision ignored late", {1'b0, led_pin}, {1'b0, 3'b111 ^ 3'b101});
  endtask

  // R7, R8, R9
  task automatic t_dual_map();
    cyc(20);
    led_mode = 1'b0; link_up = 1'b0; full_duplex = 1'b0; speed_100 = 1'b1;
    cyc(4);
    chk("R7 no link", {1'b0, led_pin}, {1'b0, 3'b000 ^ 3'b101});
    link_up = 1'b1;
    cyc(4);
    chk("R7 link 100", {1'b0, led_pin}, {1'b0, 3'b001 ^ 3'b101});
    speed_100 = 1'b0;
    cyc(4);
    chk("R7 link 10", {1'b0, led_pin}, {1'b0, 3'b010 ^ 3'b101});
    activity = 1'b1; cyc(1); activity = 1'b0;
    cyc(2);
    chk("R8 activity blanks", {1'b0, led_pin}, {1'b0, 3'b000 ^ 3'b101});
    cyc(18);
    chk("R8 activity ends", {1'b0, led_pin}, {1'b0, 3'b010 ^ 3'b101});
    full_duplex = 1'b1;
    cyc(4);
    chk("R9 full duplex", {1'b0, led_pin}, {1'b0, 3'b110 ^ 3'b101});
    collision = 1'b1; cyc(1); collision = 1'b0;
    cyc(2);
    chk("R9 collision inverts", {1'b0, led_pin}, {1'b0, 3'b010 ^ 3'b101});
    cyc(18);
    chk("R9 collision ends", {1'b0, led_pin}, {1'b0, 3'b110 ^ 3'b101});
  endtask

  // R3
  task automatic t_soft();
    soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
    cyc(3);
    chk("R3 soft boot lit", {1'b0, led_pin}, {1'b0, 3'b010});
    cyc(BOOTC + 4);
    chk("R3 soft boot done", {1'b0, led_pin}, {1'b0, 3'b110 ^ 3'b101});
  endtask

  // R11, R12, R4
  task automatic t_status();
    cable_present = 1'b1; cyc(3);
    chk("R11 cable present", {3'b0, sts_pin}, 4'h1);
    cable_present = 1'b0; cyc(3);
    chk("R11 cable absent", {3'b0, sts_pin}, 4'h0);
    led_mode = 1'b1; link_up = 1'b1; speed_100 = 1'b1; full_duplex = 1'b1;
    t_reset_boot(3'b010, 1'b1);
    chk("R4 other straps", {1'b0, led_pin}, {1'b0, 3'b111 ^ 3'b010});
    chk("R12 link up", {3'b0, sts_pin}, 4'h0);
    link_up = 1'b0; cyc(3);
    chk("R12 link down", {3'b0, sts_pin}, 4'h1);
  endtask

  initial begin
    t_reset_boot(3'b101, 1'b0);
    t_single_map();
    t_single_events();
    t_dual_map();
    t_soft();
    t_status();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule